// File: doc/BRIEF.md
# Event Performance Monitor Counter Unit

This block is a bank of profiling counters. A 64-bit counter advances once per clock, and eight 32-bit counters each follow one line picked from a shared 64-bit event bus. They add one in every cycle where that line is high and the counter is not frozen. Software reaches every counter and control field through a single-cycle register write port and a combinational read port. Every register is 32 bits wide, so the cycle counter appears as a low half and a high half.

A counter raises its condition when its top bit is set. The top bit can be set by counting from just below the threshold or by a write. The single interrupt output is the OR of all enabled conditions, gated by a global enable. It remains high until software clears the enable, or writes the counter back below the threshold. A freeze-on-condition mode stops every counter in the same cycle the interrupt appears. Hardware also sets the global freeze bit, so the counts stay captured until software releases them.

Register map (5-bit address): 0 global control (bit0 freeze-all, bit1 interrupt enable, bit2 freeze-on-condition, bit3 condition enable of the cycle counter); 1 cycle counter low half; 2 cycle counter high half; 8+n value of event counter n; 16+n control of event counter n (bits 5:0 event select, bit6 local freeze, bit7 condition enable). Unmapped addresses read as zero.

Top module: `perfmon_unit`

## Requirements
- R1: The cycle counter adds one every clock while freeze-all is clear, carries from the low half (address 1) into the high half (address 2), and either half can be written.
- R2: Event counter n adds one in each cycle where event line `sel` is high, where `sel` is bits 5:0 of its control register (any of lines 0 to 63). Other lines have no effect on it.
- R3: A counter's condition is its most significant bit. The interrupt rises in the cycle after the edge that moves a condition-enabled counter from 0x7FFFFFFF to 0x80000000.
- R4: The interrupt is high only while the global interrupt enable (bit1) is set and at least one counter has both its top bit and its condition enable set. For event counters the condition enable is control bit7; for the cycle counter it is global bit3.
- R5: With freeze-on-condition (bit2) set, no counter advances on any edge where the interrupt is high. Hardware sets freeze-all (bit0), and this wins over a software write in that cycle.
- R6: A set local freeze (control bit6) stops that event counter. A set freeze-all stops every counter, the cycle counter included.
- R7: After the freeze bits are cleared, counting resumes from the held values under the current settings.
- R8: A register write to a counter takes effect over a same-cycle increment, and writing a value with the top bit clear removes that counter's condition.
- R9: After reset all counters and control fields read zero and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| events_i | input | 64 | Shared event lines, one per selectable event |
| reg_we | input | 1 | Register write strobe, acts on the rising clock edge |
| reg_addr | input | 5 | Register address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Performance monitor interrupt |

## Verification
The hardest situation to reach from the ports is the condition itself. A counter needs two billion events to reach its top bit, and the cycle counter needs far longer. The stimulus therefore writes a counter to one or two counts below the threshold and then pulses its event line one cycle at a time, so the crossing edge is known exactly. Freeze-on-condition is tested with a second counter running on a held event line. This shows that both counters stop on the same edge. A software write that tries to clear freeze-all while the condition persists is then issued, to show that the hardware set wins.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

  // Register address map (word addresses)
  localparam int unsigned ADR_GLB      = 0;
  localparam int unsigned ADR_CYC_LO   = 1;
  localparam int unsigned ADR_CYC_HI   = 2;
  localparam int unsigned ADR_CNT_BASE = 8;
  localparam int unsigned ADR_CTL_BASE = 16;

  // Global control; field order sets the bit positions (bit3 .. bit0)
  typedef struct packed {
    logic cyc_ce;     // condition enable for the cycle counter
    logic frz_on_cnd; // freeze all counters when the interrupt is signalled
    logic irq_en;     // global interrupt enable
    logic frz_all;    // freeze every counter
  } glb_ctl_t;

  localparam int unsigned GLB_W = $bits(glb_ctl_t);

  // A condition edge: top bit low before, high now
  function automatic logic top_bit_rose(input logic prev, input logic cur);
    return cur & ~prev;
  endfunction

endpackage

// File: rtl/pm_event_counter.sv
module pm_event_counter #(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 64,
  parameter int SEL_W   = $clog2(NUM_EVT),
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] events_i,
  input  logic               frz_all_i,
  input  logic               cnt_we_i,
  input  logic               ctl_we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [SEL_W+1:0]   ctl_o,
  output logic               cond_o
);
  import perfmon_pkg::*;

  localparam int MSB   = CNT_W - 1;
  localparam int CTL_W = SEL_W + 2;

  logic [SEL_W-1:0] sel_q;
  logic             lfrz_q;
  logic             ce_q;
  logic [CNT_W-1:0] cnt_q;
  logic             msb_d;

  // Next count given an increment request
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v, input logic en);
    return v + CNT_W'(en);
  endfunction

  // Named internal events
  logic evt_hit;
  logic count_en;
  logic msb_rise;

  assign evt_hit  = events_i[sel_q];
  assign count_en = evt_hit & ~lfrz_q & ~frz_all_i;
  assign msb_rise = top_bit_rose(msb_d, cnt_q[MSB]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      lfrz_q <= 1'b0;
      ce_q   <= 1'b0;
      cnt_q  <= '0;
      msb_d  <= 1'b0;
    end else begin
      if (ctl_we_i) begin
        {ce_q, lfrz_q, sel_q} <= wdata_i[CTL_W-1:0];
      end
      if (cnt_we_i) begin
        cnt_q <= wdata_i[CNT_W-1:0];
      end else begin
        cnt_q <= bump(cnt_q, count_en);
      end
      msb_d <= cnt_q[MSB];
    end
  end

  assign cnt_o  = cnt_q;
  assign ctl_o  = {ce_q, lfrz_q, sel_q};
  assign cond_o = cnt_q[MSB] & ce_q;

  // R2: without a write the count moves by zero or one
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we_i |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(1)));

  // R6: a frozen counter holds its value
  assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((frz_all_i || lfrz_q) && !cnt_we_i) |=> $stable(cnt_q));

  // R8: a write lands regardless of the event line
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we_i |=> (cnt_q == $past(wdata_i[CNT_W-1:0])));

  // R3: the top bit rises by counting only from the value just below it
  assert_msb_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (msb_rise && !$past(cnt_we_i)) |-> ($past(cnt_q) == {1'b0, {(CNT_W-1){1'b1}}}));

endmodule

// File: rtl/pm_cycle_counter.sv
module pm_cycle_counter #(
  parameter int CYC_W  = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frz_i,
  input  logic              lo_we_i,
  input  logic              hi_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CYC_W-1:0]  cnt_o
);
  localparam int HALF = CYC_W / 2;

  logic [CYC_W-1:0] cnt_q;
  logic [CYC_W-1:0] cnt_nxt;
  logic             any_we;

  function automatic logic [CYC_W-1:0] advance(input logic [CYC_W-1:0] v, input logic hold);
    return hold ? v : v + CYC_W'(1);
  endfunction

  assign any_we = lo_we_i | hi_we_i;

  always_comb begin
    cnt_nxt = advance(cnt_q, frz_i);
    if (lo_we_i) cnt_nxt[HALF-1:0]     = wdata_i[HALF-1:0];
    if (hi_we_i) cnt_nxt[CYC_W-1:HALF] = wdata_i[HALF-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign cnt_o = cnt_q;

  // R1: free-running increment when not frozen or written
  assert_cyc_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!frz_i && !any_we) |=> (cnt_q == $past(cnt_q) + CYC_W'(1)));

  // R6: freeze-all holds the cycle counter
  assert_cyc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_i && !any_we) |=> $stable(cnt_q));

endmodule

// File: rtl/pm_irq_combine.sv
module pm_irq_combine #(
  parameter int N = 9
) (
  input  logic [N-1:0] cond_i,
  input  logic         irq_en_i,
  input  logic         frz_on_cnd_i,
  output logic         irq_o,
  output logic         frz_req_o
);
  logic any_cond;

  assign any_cond  = |cond_i;
  assign irq_o     = any_cond & irq_en_i;
  assign frz_req_o = irq_o & frz_on_cnd_i;

endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 32,
  parameter int CYC_W   = 64,
  parameter int NUM_EVT = 64,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] events_i,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_o
);
  import perfmon_pkg::*;

  localparam int SEL_W = $clog2(NUM_EVT);
  localparam int CTL_W = SEL_W + 2;
  localparam int HALF  = CYC_W / 2;
  localparam int NCND  = NUM_CNT + 1;

  glb_ctl_t         glb_q;
  logic             glb_we;
  logic             cyc_lo_we;
  logic             cyc_hi_we;
  logic [CYC_W-1:0] cyc_cnt;
  logic [NCND-1:0]  cond;
  logic             frz_req;
  logic             frz_eff;

  logic [CNT_W-1:0] cnt_arr [NUM_CNT];
  logic [CTL_W-1:0] ctl_arr [NUM_CNT];
  logic [NUM_CNT-1:0] cnt_we;
  logic [NUM_CNT-1:0] ctl_we;

  assign glb_we    = reg_we && (reg_addr == ADDR_W'(ADR_GLB));
  assign cyc_lo_we = reg_we && (reg_addr == ADDR_W'(ADR_CYC_LO));
  assign cyc_hi_we = reg_we && (reg_addr == ADDR_W'(ADR_CYC_HI));

  // Freeze acts in the same cycle the condition appears
  assign frz_eff = glb_q.frz_all | frz_req;

  pm_cycle_counter #(.CYC_W(CYC_W), .DATA_W(DATA_W)) u_cyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .frz_i   (frz_eff),
    .lo_we_i (cyc_lo_we),
    .hi_we_i (cyc_hi_we),
    .wdata_i (reg_wdata),
    .cnt_o   (cyc_cnt)
  );

  assign cond[NUM_CNT] = cyc_cnt[CYC_W-1] & glb_q.cyc_ce;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_evt
    assign cnt_we[g] = reg_we && (reg_addr == ADDR_W'(ADR_CNT_BASE + g));
    assign ctl_we[g] = reg_we && (reg_addr == ADDR_W'(ADR_CTL_BASE + g));

    pm_event_counter #(
      .CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .SEL_W(SEL_W), .DATA_W(DATA_W)
    ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .events_i  (events_i),
      .frz_all_i (frz_eff),
      .cnt_we_i  (cnt_we[g]),
      .ctl_we_i  (ctl_we[g]),
      .wdata_i   (reg_wdata),
      .cnt_o     (cnt_arr[g]),
      .ctl_o     (ctl_arr[g]),
      .cond_o    (cond[g])
    );
  end

  pm_irq_combine #(.N(NCND)) u_irq (
    .cond_i       (cond),
    .irq_en_i     (glb_q.irq_en),
    .frz_on_cnd_i (glb_q.frz_on_cnd),
    .irq_o        (irq_o),
    .frz_req_o    (frz_req)
  );

  // Global control: hardware freeze request overrides a software clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_q <= '0;
    end else begin
      if (glb_we) glb_q <= glb_ctl_t'(reg_wdata[GLB_W-1:0]);
      if (frz_req) glb_q.frz_all <= 1'b1;
    end
  end

  // Read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADR_GLB))    reg_rdata = DATA_W'(glb_q);
    if (reg_addr == ADDR_W'(ADR_CYC_LO)) reg_rdata = DATA_W'(cyc_cnt[HALF-1:0]);
    if (reg_addr == ADDR_W'(ADR_CYC_HI)) reg_rdata = DATA_W'(cyc_cnt[CYC_W-1:HALF]);
    for (int i = 0; i < NUM_CNT; i++) begin
      if (reg_addr == ADDR_W'(ADR_CNT_BASE + i)) reg_rdata = DATA_W'(cnt_arr[i]);
      if (reg_addr == ADDR_W'(ADR_CTL_BASE + i)) reg_rdata = DATA_W'(ctl_arr[i]);
    end
  end

  // R5: a freeze request leaves freeze-all set
  assert_hw_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frz_req |=> glb_q.frz_all);

  // R4: no interrupt while the global enable is clear
  assert_irq_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_q.irq_en |-> !irq_o);

  // R5: the cycle counter does not move on an edge where the interrupt freezes
  assert_cyc_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_req && !cyc_lo_we && !cyc_hi_we) |=> $stable(cyc_cnt));

endmodule

// File: tb/tb_perfmon_unit.sv
`timescale 1ns/1ps
module tb_perfmon_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] ev = '0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  perfmon_unit dut (
    .clk(clk), .rst_n(rst_n), .events_i(ev), .reg_we(we),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  typedef struct {
    bit          is_irq;
    logic [4:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];

  // Monitor: compare outputs at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = it.is_irq ? {31'b0, irq} : rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s addr=%0d actual=0x%08h expected=0x%08h", it.tag, it.a, act, it.exp);
      end
    end
  end

  // Driver tasks: each starts and ends just after a rising edge
  task automatic wr(input int a, input logic [31:0] d);
    we = 1'b1; addr = 5'(a); wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic chk(input int a, input logic [31:0] e, input string tag);
    item_t it;
    addr = 5'(a);
    it.is_irq = 0; it.a = 5'(a); it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic chk_irq(input bit e, input string tag);
    item_t it;
    it.is_irq = 1; it.a = addr; it.exp = {31'b0, e}; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic pulse(input int idx, input int n);
    ev[idx] = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    ev[idx] = 1'b0;
  endtask

  localparam int GLB = 0, CLO = 1, CHI = 2, CNT = 8, CTL = 16;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9: reset state
    chk(GLB, 0, "R9 global");
    chk(CNT + 0, 0, "R9 cnt0");
    chk(CNT + 7, 0, "R9 cnt7");
    chk(CTL + 3, 0, "R9 ctl3");
    chk_irq(0, "R9 irq");

    // R1 / R6 / R7: cycle counter
    wr(GLB, 32'h1);
    wr(CLO, 32'd100);
    chk(CLO, 100, "R6 cycle held");
    chk(CLO, 100, "R6 cycle held again");
    wr(GLB, 32'h0);
    chk(CLO, 100, "R7 cycle release edge");
    chk(CLO, 101, "R1 cycle counts");
    chk(CLO, 102, "R1 cycle counts again");
    wr(GLB, 32'h1);
    wr(CLO, 32'hFFFF_FFFF);
    wr(CHI, 32'h0);
    wr(GLB, 32'h0);
    chk(CHI, 0, "R1 high before carry");
    chk(CHI, 1, "R1 carry into high");
    chk(CLO, 1, "R1 low after carry");

    // R4: cycle counter condition through global bit3
    wr(GLB, 32'h1);
    wr(CHI, 32'h8000_0000);
    wr(GLB, 32'hB);
    chk_irq(1, "R4 cycle condition");
    wr(CHI, 32'h0);
    chk_irq(0, "R8 cycle condition cleared");
    wr(GLB, 32'h0);

    // R2: event selection, including line 63
    wr(CTL + 2, 32'd5);
    wr(CNT + 2, 32'd0);
    ev[6] = 1'b1;
    pulse(5, 3);
    ev[6] = 1'b0;
    chk(CNT + 2, 3, "R2 selected line counted");
    wr(CTL + 3, 32'd63);
    pulse(63, 2);
    chk(CNT + 3, 2, "R2 line 63");
    chk(CNT + 2, 3, "R2 other lines ignored");

    // R6 / R7: local and global freeze
    wr(CTL + 4, 32'h47);
    pulse(7, 4);
    chk(CNT + 4, 0, "R6 local freeze");
    wr(CTL + 4, 32'h07);
    pulse(7, 2);
    chk(CNT + 4, 2, "R7 local release");
    wr(GLB, 32'h1);
    pulse(7, 3);
    chk(CNT + 4, 2, "R6 global freeze");
    wr(GLB, 32'h0);
    pulse(7, 1);
    chk(CNT + 4, 3, "R7 global release");

    // R8: write beats same-cycle increment
    wr(CTL + 5, 32'd9);
    ev[9] = 1'b1;
    wr(CNT + 5, 32'd50);
    chk(CNT + 5, 50, "R8 write wins");
    chk(CNT + 5, 51, "R8 counting after write");
    ev[9] = 1'b0;

    // R3 / R4 / R8: condition and interrupt gating
    wr(GLB, 32'h2);
    wr(CTL + 6, 32'h8A);
    wr(CNT + 6, 32'h7FFF_FFFE);
    chk_irq(0, "R3 below threshold");
    pulse(10, 1);
    chk(CNT + 6, 32'h7FFF_FFFF, "R3 just below");
    chk_irq(0, "R3 still low");
    pulse(10, 1);
    chk_irq(1, "R3 top bit rose");
    chk(CNT + 6, 32'h8000_0000, "R3 crossing value");
    wr(GLB, 32'h0);
    chk_irq(0, "R4 global enable off");
    wr(GLB, 32'h2);
    chk_irq(1, "R4 global enable on");
    wr(CTL + 6, 32'h0A);
    chk_irq(0, "R4 condition enable off");
    wr(CTL + 6, 32'h8A);
    chk_irq(1, "R4 condition enable on");
    wr(CNT + 6, 32'd5);
    chk_irq(0, "R8 write clears condition");

    // R5: freeze on condition
    wr(GLB, 32'h6);
    wr(CTL + 7, 32'h8B);
    wr(CNT + 7, 32'h7FFF_FFFF);
    wr(CTL + 2, 32'd12);
    wr(CNT + 2, 32'd0);
    ev[11] = 1'b1; ev[12] = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    ev[11] = 1'b0; ev[12] = 1'b0;
    chk(CNT + 7, 32'h8000_0000, "R5 overflowing counter stopped");
    chk(CNT + 2, 1, "R5 other counter stopped");
    chk(GLB, 32'h7, "R5 freeze-all set by hardware");
    chk_irq(1, "R5 interrupt held");
    wr(GLB, 32'h6);
    chk(GLB, 32'h7, "R5 hardware set wins over write");
    wr(CNT + 7, 32'd0);
    wr(GLB, 32'h2);
    chk(GLB, 32'h2, "R7 freeze released");
    pulse(12, 3);
    chk(CNT + 2, 4, "R7 counting resumes");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule